// File: doc/BRIEF.md
# Register Region Operand Gather Unit

This block turns the operand descriptors of one SIMD instruction into per-lane byte addresses within a flat, byte-addressed register file that it holds. The descriptors are the execution size, the element size, the register number, the element offset within that register, and the region parameters. A source operand is addressed in two dimensions. Lanes advance by a horizontal stride inside a row of 2^w elements, and each new row begins a vertical stride further on than the previous row began. The destination advances by a single stride.

One instruction is accepted per cycle. The block gathers the addressed source elements into a lane vector, zero-extended to 64 bits. In the same cycle it scatters the supplied result lanes into the destination positions. Address, lane mask and gathered data appear one cycle later. The file is 128 registers of 32 bytes by default. Filling it uses the same scatter path. The arithmetic between gather and scatter and any checking of region legality happen elsewhere.

Top module: `region_gather`

## Requirements
- R1: While rst_n is low, out_valid, lane_valid, src_addr, dst_addr and src_data are all zero.
- R2: Outputs are registered. out_valid equals valid_in of the previous cycle. After a cycle with valid_in low, lane_valid, both address vectors and src_data are zero.
- R3: exec_log2 codes 0 to 4 enable lanes 0..2^code-1 (1, 2, 4, 8 or 16 lanes). Codes 5 to 7 enable all 16 lanes. lane_valid reports that mask.
- R4: For active source lane i, the element index is (i >> src_width_log2) * src_vstride + (i mod 2^src_width_log2) * src_hstride. Region <4,2,0> with 4 lanes yields 0,0,4,4. <4,2,2> yields 0,2,4,6. <8,8,1> yields lane order. <0,1,0> yields one element on every lane. <0,4,1> repeats four consecutive elements.
- R5: The source byte address is (src_reg*32 + ((src_sub + index) << elem_log2)) modulo the file size. It runs on into the following register, and past register 127 it wraps to byte 0.
- R6: The destination byte address of lane i is (dst_reg*32 + ((dst_sub + i*dst_stride) << elem_log2)) modulo the file size. Offset 1 with stride 2 writes elements 1,3,5,7.
- R7: src_data lane i (bits 64i+63..64i) holds the 2^elem_log2 bytes starting at its source address, least significant byte at the lowest address, zero above. The bytes are the file contents from before this instruction's own write.
- R8: With valid_in and wr_en high, each active lane writes the low 2^elem_log2 bytes of its res_data lane at its destination address. Every other byte of the file keeps its value.
- R9: When several active lanes target the same destination bytes, the highest-numbered lane's data is stored.
- R10: Inactive lanes report zero addresses and zero data and write nothing.
- R11: With wr_en low, the instruction leaves the file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Instruction present this cycle |
| wr_en | input | 1 | Scatter res_data into the destination |
| exec_log2 | input | 3 | Log2 of lane count (5..7 mean 16) |
| elem_log2 | input | 2 | Log2 of element size in bytes |
| src_reg | input | 7 | Source register number |
| src_sub | input | 5 | Source element offset in the register |
| src_vstride | input | 6 | Source row-to-row step in elements |
| src_width_log2 | input | 3 | Log2 of source row width |
| src_hstride | input | 6 | Source in-row step in elements |
| dst_reg | input | 7 | Destination register number |
| dst_sub | input | 5 | Destination element offset in the register |
| dst_stride | input | 6 | Destination lane step in elements |
| res_data | input | 1024 | Result lanes, 64 bits each |
| out_valid | output | 1 | Outputs below hold an instruction |
| lane_valid | output | 16 | Active-lane mask |
| src_addr | output | 192 | Source byte address, 12 bits per lane |
| dst_addr | output | 192 | Destination byte address, 12 bits per lane |
| src_data | output | 1024 | Gathered source lanes, 64 bits each |

## Verification
On every cycle, the assertions check the following. out_valid trails valid_in by one cycle. The lane mask is a contiguous run from lane 0. Inactive or idle lanes carry zero address and data. Neighbouring lanes within a source row, and neighbouring destination lanes, sit exactly one scaled stride apart. The row-to-row jump, wrapping at the end of the file, the byte contents gathered, read-before-write within one instruction, preservation of untouched bytes and the winner among overlapping lanes show only in the directed scenarios. There the bench keeps its own model of the file.

// File: rtl/rg_pkg.sv
package rg_pkg;
   // Operand descriptor field widths fixed by the instruction format.
   localparam int unsigned STRIDE_W = 6;
   localparam int unsigned WLOG_W   = 3;
   localparam int unsigned EXEC_W   = 3;
   localparam int unsigned TSZ_W    = 2;
   localparam int unsigned ELEM_W   = 64;

   // Number of enabled lanes for an execution-size code, clamped to the lane count.
   function automatic int unsigned active_lanes(input logic [EXEC_W-1:0] code,
                                                input int unsigned lanes_log2);
      return (int'(code) > int'(lanes_log2)) ? (32'd1 << lanes_log2) : (32'd1 << code);
   endfunction
endpackage

// File: rtl/rg_addr_gen.sv
module rg_addr_gen
   import rg_pkg::*;
#(
   parameter int unsigned LANES     = 16,
   parameter int unsigned REG_BYTES = 32,
   parameter int unsigned AW        = 12,
   parameter int unsigned RW        = 7,
   parameter int unsigned SW        = 5,
   parameter bit          IS_SRC    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RW-1:0]       base_reg,
   input  logic [SW-1:0]       sub,
   input  logic [STRIDE_W-1:0] vstride,
   input  logic [WLOG_W-1:0]   width_log2,
   input  logic [STRIDE_W-1:0] hstride,
   input  logic [TSZ_W-1:0]    elem_log2,
   output logic [AW-1:0]       addr [LANES]
);

   if (!IS_SRC) begin : g_dst_unused
      logic unused_region;
      assign unused_region = ^{vstride, width_log2};
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [31:0] idx;

      if (IS_SRC) begin : g_2d
         // row = lane / width, column = lane mod width
         always_comb
            idx = ((32'(l) >> width_log2) * 32'(vstride))
                + ((32'(l) & ((32'd1 << width_log2) - 32'd1)) * 32'(hstride));

         if (l > 0) begin : g_chk
            assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
               ((32'(l) & ((32'd1 << width_log2) - 32'd1)) != 32'd0)
               |-> (addr[l] == addr[l-1] + AW'(32'(hstride) << elem_log2)));
         end
      end else begin : g_1d
         always_comb idx = 32'(l) * 32'(hstride);

         if (l > 0) begin : g_chk
            assert_dst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
               addr[l] == addr[l-1] + AW'(32'(hstride) << elem_log2));
         end
      end

      // Byte address, modulo the file size by truncation.
      assign addr[l] = AW'((32'(base_reg) * REG_BYTES) + ((32'(sub) + idx) << elem_log2));
   end

endmodule

// File: rtl/rg_file.sv
module rg_file #(
   parameter int unsigned NBYTES = 4096,
   parameter int unsigned LANES  = 16,
   parameter int unsigned AW     = 12,
   parameter int unsigned EW     = 64
) (
   input  logic             clk,
   input  logic             wr_go,
   input  logic [LANES-1:0] lane_en,
   input  logic [1:0]       elem_log2,
   input  logic [AW-1:0]    wr_addr [LANES],
   input  logic [EW-1:0]    wr_data [LANES],
   input  logic [AW-1:0]    rd_addr [LANES],
   output logic [EW-1:0]    rd_data [LANES]
);
   localparam int unsigned EB = EW / 8;

   if ((EW % 8) != 0 || EB > 8) begin : g_bad_ew
      $error("rg_file: EW must be 8..64 in whole bytes");
   end
   if (NBYTES != (32'd1 << AW)) begin : g_bad_depth
      $error("rg_file: NBYTES must equal 2**AW");
   end

   logic [7:0] mem [NBYTES];

   // Ascending lane order: a later (higher) lane overrides an earlier one.
   always_ff @(posedge clk) begin
      if (wr_go) begin
         for (int l = 0; l < int'(LANES); l++) begin
            for (int k = 0; k < int'(EB); k++) begin
               if (lane_en[l] && (k < (1 << elem_log2)))
                  mem[wr_addr[l] + AW'(k)] <= wr_data[l][8*k +: 8];
            end
         end
      end
   end

   always_comb begin
      for (int l = 0; l < int'(LANES); l++) begin
         rd_data[l] = '0;
         for (int k = 0; k < int'(EB); k++) begin
            if (k < (1 << elem_log2))
               rd_data[l][8*k +: 8] = mem[rd_addr[l] + AW'(k)];
         end
      end
   end

endmodule

// File: rtl/region_gather.sv
module region_gather
   import rg_pkg::*;
#(
   parameter int unsigned NREG      = 128,
   parameter int unsigned REG_BYTES = 32,
   parameter int unsigned LANES     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          valid_in,
   input  logic                          wr_en,
   input  logic [2:0]                    exec_log2,
   input  logic [1:0]                    elem_log2,
   input  logic [$clog2(NREG)-1:0]       src_reg,
   input  logic [$clog2(REG_BYTES)-1:0]  src_sub,
   input  logic [5:0]                    src_vstride,
   input  logic [2:0]                    src_width_log2,
   input  logic [5:0]                    src_hstride,
   input  logic [$clog2(NREG)-1:0]       dst_reg,
   input  logic [$clog2(REG_BYTES)-1:0]  dst_sub,
   input  logic [5:0]                    dst_stride,
   input  logic [LANES*64-1:0]           res_data,
   output logic                          out_valid,
   output logic [LANES-1:0]              lane_valid,
   output logic [LANES*$clog2(NREG*REG_BYTES)-1:0] src_addr,
   output logic [LANES*$clog2(NREG*REG_BYTES)-1:0] dst_addr,
   output logic [LANES*64-1:0]           src_data
);
   localparam int unsigned NBYTES = NREG * REG_BYTES;
   localparam int unsigned AW     = $clog2(NBYTES);
   localparam int unsigned RW     = $clog2(NREG);
   localparam int unsigned SW     = $clog2(REG_BYTES);
   localparam int unsigned LW     = $clog2(LANES);

   if (LANES < 1 || LANES > 16 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("region_gather: LANES must be a power of two up to 16");
   end
   if ((NREG & (NREG - 1)) != 0 || (REG_BYTES & (REG_BYTES - 1)) != 0) begin : g_bad_file
      $error("region_gather: NREG and REG_BYTES must be powers of two");
   end

   logic [AW-1:0]     sa [LANES];
   logic [AW-1:0]     da [LANES];
   logic [ELEM_W-1:0] wdata [LANES];
   logic [ELEM_W-1:0] rdata [LANES];
   logic [LANES-1:0]  act;

   always_comb begin
      for (int l = 0; l < int'(LANES); l++)
         act[l] = 32'(l) < active_lanes(exec_log2, LW);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_unpack
      assign wdata[l] = res_data[l*ELEM_W +: ELEM_W];
   end

   rg_addr_gen #(
      .LANES(LANES), .REG_BYTES(REG_BYTES), .AW(AW), .RW(RW), .SW(SW), .IS_SRC(1'b1)
   ) u_src_gen (
      .clk(clk), .rst_n(rst_n), .base_reg(src_reg), .sub(src_sub),
      .vstride(src_vstride), .width_log2(src_width_log2), .hstride(src_hstride),
      .elem_log2(elem_log2), .addr(sa)
   );

   rg_addr_gen #(
      .LANES(LANES), .REG_BYTES(REG_BYTES), .AW(AW), .RW(RW), .SW(SW), .IS_SRC(1'b0)
   ) u_dst_gen (
      .clk(clk), .rst_n(rst_n), .base_reg(dst_reg), .sub(dst_sub),
      .vstride('0), .width_log2('0), .hstride(dst_stride),
      .elem_log2(elem_log2), .addr(da)
   );

   rg_file #(
      .NBYTES(NBYTES), .LANES(LANES), .AW(AW), .EW(ELEM_W)
   ) u_file (
      .clk(clk), .wr_go(valid_in & wr_en), .lane_en(act), .elem_log2(elem_log2),
      .wr_addr(da), .wr_data(wdata), .rd_addr(sa), .rd_data(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         lane_valid <= '0;
         src_addr   <= '0;
         dst_addr   <= '0;
         src_data   <= '0;
      end else begin
         out_valid <= valid_in;
         for (int l = 0; l < int'(LANES); l++) begin
            lane_valid[l]                 <= valid_in & act[l];
            src_addr[l*AW +: AW]          <= (valid_in && act[l]) ? sa[l] : '0;
            dst_addr[l*AW +: AW]          <= (valid_in && act[l]) ? da[l] : '0;
            src_data[l*ELEM_W +: ELEM_W]  <= (valid_in && act[l]) ? rdata[l] : '0;
         end
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(valid_in));

   assert_idle_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (lane_valid == '0));

   assert_mask_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lane_valid[0] && ($countones({1'b0, lane_valid} + 1'b1) == 1)));

   for (genvar l = 0; l < LANES; l++) begin : g_chk_lane
      assert_inactive_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_valid[l] |-> (src_addr[l*AW +: AW] == '0 && dst_addr[l*AW +: AW] == '0
                              && src_data[l*ELEM_W +: ELEM_W] == '0));
   end

endmodule

// File: tb/sim_region_gather.sv
module sim_region_gather;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    exec_log2 = '0;
   logic [1:0]    elem_log2 = '0;
   logic [6:0]    src_reg = '0, dst_reg = '0;
   logic [4:0]    src_sub = '0, dst_sub = '0;
   logic [5:0]    src_vstride = '0, src_hstride = '0, dst_stride = '0;
   logic [2:0]    src_width_log2 = '0;
   logic [1023:0] res_data = '0;
   logic          out_valid;
   logic [15:0]   lane_valid;
   logic [191:0]  src_addr, dst_addr;
   logic [1023:0] src_data;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  chk_data = 1'b1;
   logic [7:0] mdl [4096];

   always #4 clk = ~clk;

   region_gather u0 (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .wr_en(wr_en),
      .exec_log2(exec_log2), .elem_log2(elem_log2),
      .src_reg(src_reg), .src_sub(src_sub), .src_vstride(src_vstride),
      .src_width_log2(src_width_log2), .src_hstride(src_hstride),
      .dst_reg(dst_reg), .dst_sub(dst_sub), .dst_stride(dst_stride),
      .res_data(res_data), .out_valid(out_valid), .lane_valid(lane_valid),
      .src_addr(src_addr), .dst_addr(dst_addr), .src_data(src_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [1023:0] got, input logic [1023:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   function automatic int src_byte(input int l);
      int idx;
      idx = (l >> int'(src_width_log2)) * int'(src_vstride)
          + (l & ((1 << int'(src_width_log2)) - 1)) * int'(src_hstride);
      return (int'(src_reg) * 32 + ((int'(src_sub) + idx) << int'(elem_log2))) % 4096;
   endfunction

   function automatic int dst_byte(input int l);
      return (int'(dst_reg) * 32 + ((int'(dst_sub) + l * int'(dst_stride)) << int'(elem_log2))) % 4096;
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7) + (a >> 8) * 13 + 5);
   endfunction

   task automatic set_op(input int e, input int t, input bit we);
      exec_log2 = 3'(e); elem_log2 = 2'(t); wr_en = we;
   endtask

   task automatic set_src(input int r, input int s, input int v, input int w, input int h);
      src_reg = 7'(r); src_sub = 5'(s); src_vstride = 6'(v);
      src_width_log2 = 3'(w); src_hstride = 6'(h);
   endtask

   task automatic set_dst(input int r, input int s, input int st);
      dst_reg = 7'(r); dst_sub = 5'(s); dst_stride = 6'(st);
   endtask

   // Issue one instruction, check its outputs one cycle later, update the model.
   task automatic do_instr(input string tag);
      logic [1023:0] e_sa, e_da, e_sd;
      logic [15:0]   e_lv;
      int n;
      e_sa = '0; e_da = '0; e_sd = '0; e_lv = '0;
      n = (exec_log2 > 3'd4) ? 16 : (1 << exec_log2);
      for (int l = 0; l < 16; l++) begin
         if (l < n) begin
            int a;
            int b;
            a = src_byte(l);
            b = dst_byte(l);
            e_lv[l] = 1'b1;
            e_sa[l*12 +: 12] = 12'(a);
            e_da[l*12 +: 12] = 12'(b);
            for (int k = 0; k < (1 << elem_log2); k++)
               e_sd[l*64 + 8*k +: 8] = mdl[(a + k) % 4096];
         end
      end
      @(negedge clk);
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      chk("R2", "out_valid", 1024'(out_valid), 1024'(1));
      chk("R3", "lane_valid", 1024'(lane_valid), 1024'(e_lv));
      chk(tag, "src_addr", 1024'(src_addr), e_sa);
      chk(tag, "dst_addr", 1024'(dst_addr), e_da);
      if (chk_data) chk(tag, "src_data", src_data, e_sd);
      if (wr_en) begin
         for (int l = 0; l < n; l++) begin
            for (int k = 0; k < (1 << elem_log2); k++)
               mdl[(dst_byte(l) + k) % 4096] = res_data[l*64 + 8*k +: 8];
         end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "out_valid in reset", 1024'(out_valid), '0);
      chk("R1", "lane_valid in reset", 1024'(lane_valid), '0);
      chk("R1", "addresses in reset", 1024'({src_addr, dst_addr}), '0);
      chk("R1", "src_data in reset", src_data, '0);
   endtask

   task automatic t_fill();
      chk_data = 1'b0;
      for (int r = 0; r < 32; r++) begin
         set_op(4, 3, 1'b1);
         set_dst(r * 4, 0, 1);
         set_src(0, 0, 8, 3, 1);
         for (int l = 0; l < 16; l++)
            for (int k = 0; k < 8; k++)
               res_data[l*64 + 8*k +: 8] = pat(r * 128 + l * 8 + k);
         do_instr("R8");
      end
      chk_data = 1'b1;
   endtask

   task automatic t_idle();
      set_op(3, 2, 1'b0);
      set_src(3, 1, 8, 3, 1);
      do_instr("R4");
      @(negedge clk);
      chk("R2", "out_valid idle", 1024'(out_valid), '0);
      chk("R2", "lane_valid idle", 1024'(lane_valid), '0);
      chk("R2", "outputs idle", src_data | 1024'({src_addr, dst_addr}), '0);
   endtask

   task automatic t_hstride0();
      set_op(2, 2, 1'b0);
      set_src(5, 0, 4, 1, 0);
      set_dst(0, 0, 1);
      do_instr("R4");
      chk("R4", "<4,2,0> lane elements",
          1024'({src_addr[36 +: 12], src_addr[24 +: 12], src_addr[12 +: 12], src_addr[0 +: 12]}),
          1024'({12'(160 + 16), 12'(160 + 16), 12'(160), 12'(160)}));
   endtask

   task automatic t_hstride2_dst();
      set_op(2, 2, 1'b1);
      set_src(8, 0, 4, 1, 2);
      set_dst(6, 1, 2);
      for (int l = 0; l < 16; l++) res_data[l*64 +: 64] = 64'hA5A5_0000_1111_0000 + 64'(l);
      do_instr("R6");
      chk("R4", "<4,2,2> lane elements",
          1024'({src_addr[36 +: 12], src_addr[24 +: 12], src_addr[12 +: 12], src_addr[0 +: 12]}),
          1024'({12'(256 + 24), 12'(256 + 16), 12'(256 + 8), 12'(256)}));
      chk("R6", "dst elements 1,3,5,7",
          1024'({dst_addr[36 +: 12], dst_addr[24 +: 12], dst_addr[12 +: 12], dst_addr[0 +: 12]}),
          1024'({12'(192 + 28), 12'(192 + 20), 12'(192 + 12), 12'(192 + 4)}));
      // Read register 6 and its neighbour: untouched elements and inactive lanes preserved.
      set_op(4, 2, 1'b0);
      set_src(6, 0, 8, 3, 1);
      do_instr("R8");
      set_src(6, 0, 8, 3, 1);
      do_instr("R10");
   endtask

   task automatic t_regions();
      set_op(3, 2, 1'b0);
      set_src(12, 0, 8, 3, 1);
      do_instr("R4");
      set_op(4, 2, 1'b0);
      set_src(13, 3, 0, 0, 0);
      do_instr("R4");
      set_op(3, 2, 1'b0);
      set_src(14, 2, 0, 2, 1);
      do_instr("R4");
      set_op(4, 1, 1'b0);
      set_src(15, 1, 5, 2, 3);
      do_instr("R4");
   endtask

   task automatic t_cross_wrap();
      set_op(3, 3, 1'b0);
      set_src(10, 2, 8, 3, 1);
      do_instr("R5");
      set_op(2, 3, 1'b0);
      set_src(127, 2, 8, 3, 1);
      do_instr("R5");
      chk("R5", "wrap to byte 0", 1024'(src_addr[24 +: 12]), 1024'(0));
   endtask

   task automatic t_read_before_write();
      set_op(3, 2, 1'b1);
      set_src(20, 0, 8, 3, 1);
      set_dst(20, 0, 1);
      for (int l = 0; l < 16; l++) res_data[l*64 +: 64] = 64'h0BAD_0000_C0DE_0000 + 64'(l * 3);
      do_instr("R7");
      set_op(3, 2, 1'b0);
      do_instr("R8");
   endtask

   task automatic t_overlap();
      set_op(2, 2, 1'b1);
      set_dst(30, 0, 0);
      for (int l = 0; l < 16; l++) res_data[l*64 +: 64] = 64'(32'h7700_0000 + l);
      do_instr("R9");
      set_op(0, 2, 1'b0);
      set_src(30, 0, 0, 0, 0);
      do_instr("R9");
      chk("R9", "highest lane stored", 1024'(src_data[31:0]), 1024'(32'h7700_0003));
   endtask

   task automatic t_no_write();
      set_op(3, 2, 1'b0);
      set_dst(40, 0, 1);
      for (int l = 0; l < 16; l++) res_data[l*64 +: 64] = '1;
      do_instr("R11");
      set_src(40, 0, 8, 3, 1);
      do_instr("R11");
   endtask

   task automatic t_sizes();
      set_op(3, 0, 1'b0);
      set_src(50, 3, 8, 3, 1);
      do_instr("R7");
      set_op(3, 1, 1'b0);
      do_instr("R7");
   endtask

   task automatic t_exec_sizes();
      for (int e = 0; e < 8; e++) begin
         set_op(e, 2, 1'b0);
         set_src(60, 0, 8, 3, 1);
         set_dst(61, 0, 1);
         do_instr("R3");
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog got hung exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_fill();
      t_idle();
      t_hstride0();
      t_hstride2_dst();
      t_regions();
      t_cross_wrap();
      t_read_before_write();
      t_overlap();
      t_no_write();
      t_sizes();
      t_exec_sizes();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule